// File: doc/BRIEF.md
# Mini UART

A small asynchronous serial port sitting on a plain 32-bit register bus. Software programs a 16-bit rate divisor, chooses 7-bit or 8-bit characters, turns the receiver and the transmitter on independently, and moves characters through one data register. Characters written there queue in an 8-entry transmit FIFO. Characters received queue in an 8-entry receive FIFO.

The serial side runs on an oversampling tick at eight ticks per bit. The tick period is (divisor + 1) clock cycles. A frame is one low start bit, the data bits least significant first, and one high stop bit, with no parity. The status register reports three conditions separately: a received character is waiting, the transmit queue has room, and the transmitter has gone completely quiet. One interrupt line combines the receive and transmit conditions under separate enable bits. One modem-control bit drives the active-low RTS output.

Top module: `mini_uart`

## Requirements
- R1: After reset, TX and RTS are high and IRQ is low. A status read returns 0x60, and the control, divisor, line-control and interrupt-enable registers read 0.
- R2: Every serial bit, the start bit included, lasts exactly 8 × (divisor + 1) clock cycles.
- R3: A frame is a low start bit, the data bits LSB first, then a high stop bit. Line-control bit 0 set (for example the value 3) selects 8 data bits. Bit 0 clear selects 7 data bits, and data bit 7 is then not sent.
- R4: Status bit 5 is 1 while the transmit FIFO holds fewer than 8 bytes. A data write to a full transmit FIFO is discarded.
- R5: Status bit 6 is 1 only when the transmit FIFO is empty and no frame is in progress. It is 0 while the last stop bit is still being sent.
- R6: Status bit 0 is 1 while the receive FIFO is non-empty. A data-register read pops one byte into rdata[7:0]. A read with the FIFO empty returns 0.
- R7: Control bit 0 enables the receiver and bit 1 enables the transmitter. With the transmitter off, queued bytes stay queued and TX stays high. With the receiver off, frames on RX are ignored.
- R8: The receiver re-checks the start bit 4 ticks after it sees the falling edge and abandons the frame if RX is high by then. It samples each further bit 8 ticks apart. A frame whose stop bit is low is discarded, and the receiver waits for RX to return high before it looks for a new start bit.
- R9: IRQ = (enable bit 0 AND receive FIFO non-empty) OR (enable bit 1 AND transmit FIFO empty). Writing 0 to the interrupt-enable register forces IRQ low.
- R10: RTS is low when modem-control bit 1 is set, and high otherwise.
- R11: The byte offsets are: data 0x40, interrupt enable 0x44, line control 0x4C, modem control 0x50, status 0x54, control 0x60, divisor 0x68. A read returns its value on rdata one cycle after rd_en. Unused bits and unmapped offsets read 0, and the divisor keeps only 16 bits.
- R12: Each FIFO holds 8 bytes. A byte that completes reception while the receive FIFO is full is dropped, and the 8 stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| tx | output | 1 | Serial transmit line |
| rx | input | 1 | Serial receive line |
| rts | output | 1 | Request-to-send, active low |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that the line is high whenever the transmitter is idle. They also check that neither FIFO count passes its depth, that a write into a full transmit queue leaves the count at full, and that reading an empty receive queue returns zero. They further check that masking the interrupt or clearing the RTS bit takes effect on the next cycle, and that the idle status bit is never reported during a frame. Bit length, bit order, 7-bit truncation, rejection of start glitches and bad stop bits, the enable bits and receive overflow can only be shown by the bench's scenarios. The bench drives and decodes real frames for these, some of them in loopback through the block's own transmitter.

// File: rtl/mini_uart.sv
module mini_uart #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              tx,
  input  logic              rx,
  output logic              rts,
  output logic              irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] A_MDM  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h54);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(8'h68);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  typedef enum logic [1:0] {T_IDLE, T_START, T_DATA, T_STOP} tx_st_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAIT} rx_st_t;

  logic [1:0]       ien, line, ctl;
  logic             mdm_rts;
  logic [DIV_W-1:0] div;
  logic             unused_hi;
  assign unused_hi = ^wdata[31:DIV_W];

  wire wr_dat = wr_en && addr == A_DATA;
  wire rd_dat = rd_en && addr == A_DATA;
  wire [2:0] last_bit = line[0] ? 3'd7 : 3'd6;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien <= '0; line <= '0; ctl <= '0; mdm_rts <= 1'b0; div <= '0;
    end else if (wr_en) begin
      case (addr)
        A_IEN:  ien <= wdata[1:0];
        A_LINE: line <= wdata[1:0];
        A_MDM:  mdm_rts <= wdata[1];
        A_CTL:  ctl <= wdata[1:0];
        A_DIV:  div <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end

  // transmit queue
  logic [7:0]    txq [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_count;
  logic          tx_pop;
  wire tx_push = wr_dat && tx_count != FULL;

  always_ff @(posedge clk)
    if (tx_push) txq[tx_wp] <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LASTP) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LASTP) ? '0 : tx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10: tx_count <= tx_count + 1'b1;
        2'b01: tx_count <= tx_count - 1'b1;
        default: ;
      endcase
    end

  // transmitter
  tx_st_t           tx_st;
  logic [DIV_W-1:0] tx_pre;
  logic [2:0]       tx_sub, tx_bit;
  logic [7:0]       tx_sh;
  logic             tx_out;
  wire tx_tick = tx_pre >= div;
  wire tx_busy = tx_st != T_IDLE;
  assign tx_pop = !tx_busy && ctl[1] && tx_count != '0;
  assign tx = tx_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= T_IDLE; tx_out <= 1'b1; tx_pre <= '0;
      tx_sub <= '0; tx_bit <= '0; tx_sh <= '0;
    end else if (!tx_busy) begin
      if (tx_pop) begin
        tx_st <= T_START; tx_out <= 1'b0; tx_sh <= txq[tx_rp];
        tx_pre <= '0; tx_sub <= '0;
      end
    end else begin
      tx_pre <= tx_tick ? '0 : tx_pre + 1'b1;
      if (tx_tick) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == 3'd7)
          case (tx_st)
            T_START: begin tx_st <= T_DATA; tx_out <= tx_sh[0]; tx_bit <= '0; end
            T_DATA:
              if (tx_bit == last_bit) begin
                tx_st <= T_STOP; tx_out <= 1'b1;
              end else begin
                tx_bit <= tx_bit + 1'b1;
                tx_sh <= {1'b0, tx_sh[7:1]};
                tx_out <= tx_sh[1];
              end
            default: tx_st <= T_IDLE;
          endcase
      end
    end

  // receiver
  rx_st_t           rx_st;
  logic             rx_m, rx_s;
  logic [DIV_W-1:0] rx_pre;
  logic [2:0]       rx_sub, rx_bit;
  logic [7:0]       rx_sh;
  logic             rx_done;
  wire rx_tick = rx_pre >= div;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_st <= R_IDLE; rx_pre <= '0;
      rx_sub <= '0; rx_bit <= '0; rx_sh <= '0; rx_done <= 1'b0;
    end else begin
      rx_m <= rx; rx_s <= rx_m; rx_done <= 1'b0;
      case (rx_st)
        R_IDLE:
          if (ctl[0] && !rx_s) begin
            rx_st <= R_START; rx_pre <= '0; rx_sub <= '0;
          end
        R_WAIT: if (rx_s) rx_st <= R_IDLE;
        default: begin
          rx_pre <= rx_tick ? '0 : rx_pre + 1'b1;
          if (rx_tick) begin
            rx_sub <= rx_sub + 1'b1;
            if (rx_st == R_START && rx_sub == 3'd3) begin
              rx_sub <= '0; rx_bit <= '0;
              rx_st <= rx_s ? R_IDLE : R_DATA;
            end else if (rx_sub == 3'd7) begin
              if (rx_st == R_DATA) begin
                rx_sh <= {rx_s, rx_sh[7:1]};
                if (rx_bit == last_bit) rx_st <= R_STOP;
                else rx_bit <= rx_bit + 1'b1;
              end else begin
                rx_done <= rx_s;
                rx_st <= rx_s ? R_IDLE : R_WAIT;
              end
            end
          end
        end
      endcase
    end

  // receive queue
  logic [7:0]    rxq [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_count;
  wire rx_push = rx_done && rx_count != FULL;
  wire rx_pop  = rd_dat && rx_count != '0;
  wire [7:0] rx_byte = line[0] ? rx_sh : {1'b0, rx_sh[7:1]};

  always_ff @(posedge clk)
    if (rx_push) rxq[rx_wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LASTP) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LASTP) ? '0 : rx_rp + 1'b1;
      case ({rx_push, rx_pop})
        2'b10: rx_count <= rx_count + 1'b1;
        2'b01: rx_count <= rx_count - 1'b1;
        default: ;
      endcase
    end

  // status, read path, side outputs
  wire rx_avail = rx_count != '0;
  wire tx_room  = tx_count != FULL;
  wire tx_quiet = tx_count == '0 && !tx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en)
      case (addr)
        A_DATA: rdata <= rx_avail ? {24'd0, rxq[rx_rp]} : '0;
        A_IEN:  rdata <= {30'd0, ien};
        A_LINE: rdata <= {30'd0, line};
        A_MDM:  rdata <= {30'd0, mdm_rts, 1'b0};
        A_STAT: rdata <= {25'd0, tx_quiet, tx_room, 4'd0, rx_avail};
        A_CTL:  rdata <= {30'd0, ctl};
        A_DIV:  rdata <= 32'(div);
        default: rdata <= '0;
      endcase

  assign rts = !mdm_rts;
  assign irq = (ien[0] && rx_avail) || (ien[1] && tx_count == '0);
endmodule

// File: rtl/mini_uart_checker.sv
module mini_uart_checker #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        wlow,
  input logic [31:0]       rdata,
  input logic              tx,
  input logic              rts,
  input logic              irq,
  input logic              tx_busy,
  input logic              tx_pop,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_MDM  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h54);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assert_line_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx);
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= FULL && rx_count <= FULL);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && tx_count == FULL && !tx_pop) |=> tx_count == FULL);
  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DATA && rx_count == '0) |=> rdata == 32'd0);
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IEN && wlow == 2'b00) |=> !irq);
  assert_rts_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MDM && !wlow[1]) |=> rts);
  assert_busy_not_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT && tx_busy) |=> !rdata[6]);
endmodule

bind mini_uart mini_uart_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wlow(wdata[1:0]), .rdata(rdata), .tx(tx), .rts(rts), .irq(irq),
  .tx_busy(tx_busy), .tx_pop(tx_pop), .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/mini_uart_test.sv
module mini_uart_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx, rts, irq;
  logic        loop = 1'b0, rx_drv = 1'b1;
  wire         rx_line = loop ? tx : rx_drv;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  mini_uart uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                 .wdata(wdata), .rdata(rdata), .tx(tx), .rx(rx_line), .rts(rts), .irq(irq));

  localparam logic [7:0] DAT = 8'h40, IEN = 8'h44, LIN = 8'h4C, MDM = 8'h50,
                         STA = 8'h54, CTL = 8'h60, DIV = 8'h68;

  // {offset, write value, expected readback}
  localparam logic [71:0] VECS [10] = '{
    {IEN, 32'h0000_00FF, 32'h3}, {LIN, 32'h0000_0003, 32'h3},
    {LIN, 32'h0000_FFFE, 32'h2}, {MDM, 32'h0000_0002, 32'h2},
    {MDM, 32'h0000_00FD, 32'h0}, {CTL, 32'h0000_0003, 32'h3},
    {CTL, 32'h0000_0000, 32'h0}, {DIV, 32'h0001_2345, 32'h2345},
    {8'h48, 32'h0000_0005, 32'h0}, {IEN, 32'h0000_0000, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_quiet();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(STA, s);
      if (s[6]) break;
    end
  endtask

  task automatic wait_low(output int ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (tx === 1'b0) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure_start(output int len);
    int ok;
    wait_low(ok);
    len = 0;
    while (tx === 1'b0 && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic capture(input int b, input int n, output logic [7:0] d, output logic stopv);
    int ok;
    d = '0;
    wait_low(ok);
    repeat (b / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      repeat (b) @(negedge clk);
      d[i] = tx;
    end
    repeat (b) @(negedge clk);
    stopv = tx;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stopv, input int b);
    @(negedge clk); rx_drv = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = d[i]; repeat (b) @(negedge clk); end
    rx_drv = stopv;
    repeat (b) @(negedge clk);
    rx_drv = 1'b1;
    repeat (b) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  d;
    logic        sb;
    int          len;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx", {31'd0, tx}, 32'd1);
    check("R1 rts", {31'd0, rts}, 32'd1);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(STA, v); check("R1 status", v, 32'h60);
    rd(CTL, v); check("R1 control", v, 32'h0);
    rd(DIV, v); check("R1 divisor", v, 32'h0);
    rd(LIN, v); check("R1 line", v, 32'h0);
    rd(IEN, v); check("R1 ien", v, 32'h0);

    foreach (VECS[i]) begin
      wr(VECS[i][71:64], VECS[i][63:32]);
      rd(VECS[i][71:64], v);
      check("R11 readback", v, VECS[i][31:0]);
    end

    // R2: bit length
    wr(LIN, 3); wr(DIV, 1); wr(CTL, 2);
    wr(DAT, 8'hA5); measure_start(len);
    check("R2 start bit div=1", 32'(len), 32'd16);
    wait_quiet();
    wr(DIV, 2);
    wr(DAT, 8'h01); measure_start(len);
    check("R2 start bit div=2", 32'(len), 32'd24);
    wait_quiet();
    wr(DIV, 1);

    // R3: frame contents
    wr(DAT, 8'hA5); capture(16, 8, d, sb);
    check("R3 data A5", {24'd0, d}, 32'hA5); check("R3 stop", {31'd0, sb}, 32'd1);
    wait_quiet();
    wr(DAT, 8'h3C); capture(16, 8, d, sb);
    check("R3 data 3C", {24'd0, d}, 32'h3C);
    wait_quiet();
    wr(LIN, 2);
    wr(DAT, 8'hD5); capture(16, 7, d, sb);
    check("R3 7-bit data", {24'd0, d}, 32'h55); check("R3 7-bit stop", {31'd0, sb}, 32'd1);
    wait_quiet();
    wr(LIN, 3);

    // R5: busy on last frame
    wr(DAT, 8'h77);
    repeat (3) @(negedge clk);
    rd(STA, v); check("R5 busy status", v, 32'h20);
    wait_quiet();
    rd(STA, v); check("R5 quiet status", v, 32'h60);

    // R7 / R4: transmitter off, fill queue
    wr(CTL, 0);
    for (int i = 0; i < 9; i++) begin
      wr(DAT, 32'h10 + i);
      if (i == 6) begin rd(STA, v); check("R4 room at 7", v, 32'h20); end
    end
    rd(STA, v); check("R4 full status", v, 32'h00);
    len = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (tx !== 1'b1) len++; end
    check("R7 tx held while off", 32'(len), 32'd0);

    // R12 / R6: loopback drain
    loop = 1'b1; wr(CTL, 3);
    wait_quiet();
    rd(STA, v); check("R6 rx waiting", v, 32'h61);
    for (int i = 0; i < 8; i++) begin
      rd(DAT, v); check("R12 loopback byte", v, 32'h10 + i);
    end
    rd(STA, v); check("R6 drained status", v, 32'h60);
    rd(DAT, v); check("R6 empty read", v, 32'h0);

    // R12: receive overflow, R9 interrupt
    wr(DIV, 0); wr(CTL, 0);
    for (int i = 0; i < 8; i++) wr(DAT, 32'h20 + i);
    wr(CTL, 3); wait_quiet();
    wr(DAT, 8'h28); wait_quiet();
    wr(IEN, 1); @(negedge clk); check("R9 rx irq", {31'd0, irq}, 32'd1);
    wr(IEN, 2); @(negedge clk); check("R9 tx empty irq", {31'd0, irq}, 32'd1);
    wr(IEN, 0); @(negedge clk); check("R9 masked", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(DAT, v); check("R12 kept byte", v, 32'h20 + i);
    end
    rd(STA, v); check("R12 ninth dropped", v, 32'h60);
    wr(IEN, 1); @(negedge clk); check("R9 rx empty no irq", {31'd0, irq}, 32'd0);
    wr(IEN, 0);

    // R7: receiver off
    loop = 1'b0; wr(DIV, 1); wr(CTL, 2);
    send_rx(8'h5A, 1'b1, 16);
    rd(STA, v); check("R7 rx ignored", v, 32'h60);

    // R8 / R6: direct receive, glitch, bad stop
    wr(CTL, 3);
    send_rx(8'h96, 1'b1, 16);
    rd(STA, v); check("R6 byte waiting", v, 32'h61);
    rd(DAT, v); check("R6 byte value", v, 32'h96);
    @(negedge clk); rx_drv = 1'b0;
    repeat (4) @(negedge clk); rx_drv = 1'b1;
    repeat (40) @(negedge clk);
    rd(STA, v); check("R8 glitch rejected", v, 32'h60);
    @(negedge clk); rx_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = 1'b1; repeat (16) @(negedge clk); end
    rx_drv = 1'b0; repeat (40) @(negedge clk);
    rx_drv = 1'b1; repeat (32) @(negedge clk);
    rd(STA, v); check("R8 bad stop dropped", v, 32'h60);
    send_rx(8'h33, 1'b1, 16);
    rd(DAT, v); check("R8 recovered", v, 32'h33);

    // R10
    wr(MDM, 2); @(negedge clk); check("R10 rts low", {31'd0, rts}, 32'd0);
    wr(MDM, 0); @(negedge clk); check("R10 rts high", {31'd0, rts}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule